// File: doc/BRIEF.md
# Flash Sector Protection Gate

This block sits in the write path of a boot-sector flash array. It decides whether a program or erase request may proceed. It decodes the incoming linear address into a sector index and a protection-group index. The layout has one region of large sectors and eight small boot sectors. A parameter places the boot sectors at the top or at the bottom of the address space. A register holds one protect bit per group. Group-protect requests and chip-unprotect requests update that register.

Three plain logic flags change how the stored bits are used:

- An active-low write-protect input always guards the two outermost boot sectors.
- An acceleration flag lifts protection from every sector.
- A temporary-unprotect flag lifts stored protection while it is asserted. The write-protect guard still applies.

Each request produces a one-cycle acknowledge, together with an allow or ignore verdict. The stored protect bit for the addressed sector is also available as a readout.

Top module: `fspg_gate`

## Requirements
- R1: With top boot, the sector field F is `lin_addr[20:12]` in word mode. For F < 504 the sector is F/8 and the group is F/32. For F ≥ 504 the sector is 63+(F−504) and the group is 16+(F−504).
- R2: With bottom boot, for F < 8 the sector and the group both equal F. Otherwise the sector is F/8+7 and the group is 8+F/32.
- R3: In byte mode (`byte_mode`=1) the sector field is taken from `lin_addr[21:13]`. In word mode it is taken from `lin_addr[20:12]`, and bit 21 is unused.
- R4: An `op_req` in cycle N gives `op_ack`=1 in cycle N+1. In that cycle `op_allow`=1 exactly when the addressed sector was not effectively protected in cycle N.
- R5: `prot_grp_req` sets the protect bit of the addressed group. `sect_locked` then reads 1 for every sector of that group and 0 for sectors in other groups.
- R6: While `wp_n`=0, requests to the two outermost boot sectors are ignored. These are sectors 69 and 70 with top boot, and sectors 0 and 1 with bottom boot. Their stored bits do not matter.
- R7: While `wp_n`=1, the two outermost boot sectors follow their stored protect bits.
- R8: While `acc_active`=1, every request is allowed, whatever the other inputs are.
- R9: While `temp_unprot`=1, requests to stored-protected sectors are allowed, except for sectors guarded by R6. The stored bits are kept unchanged, so protection returns as soon as the flag drops.
- R10: `chip_unprot_req` clears all protect bits when every group is protected. Otherwise it sets all of them. It takes priority over `prot_grp_req` in the same cycle.
- R11: Reset loads the protect bits from parameter `PROT_INIT`. The default value is all zero, meaning unprotected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lin_addr | input | 22 | Linear address of the request (byte or word units) |
| byte_mode | input | 1 | 1: `lin_addr` is a byte address; 0: word address |
| op_req | input | 1 | Program or erase request for the addressed sector |
| prot_grp_req | input | 1 | Protect the group holding the addressed sector |
| chip_unprot_req | input | 1 | Chip-unprotect request (R10) |
| wp_n | input | 1 | Active-low write protect of the outer boot sectors |
| acc_active | input | 1 | Acceleration mode: everything unprotected |
| temp_unprot | input | 1 | Temporary unprotect of stored protection |
| sector_idx | output | 7 | Decoded sector index |
| group_idx | output | 5 | Decoded protection group index |
| sect_locked | output | 1 | Stored protect bit of the addressed sector |
| eff_locked | output | 1 | Effective protection of the addressed sector now |
| op_ack | output | 1 | One-cycle acknowledge of a request |
| op_allow | output | 1 | Verdict valid with `op_ack`: 1 allowed, 0 ignored |

## Verification
The bench sweeps every sector field value in both address modes on both boot layouts. A shifted field or a misplaced boot region therefore shows up as a wrong sector index or a wrong group index.

It also probes the edges of the groups:

- the three-sector group at sectors 60 to 62, where a uniform groups-of-four decode would leak the protection into sector 63;
- the boundary between the big sectors and the boot sectors.

The interaction of the flags is tested one layer at a time:

- The write-protect guard must hold during a temporary unprotect. A design that lets the temporary flag win would allow writes to the outer sector.
- Acceleration must override even the write-protect guard.
- Dropping the temporary flag must restore the stored protection. A design that cleared the stored bits would not restore it.

Chip unprotect is exercised from a partly protected state, where a naive clear would skip the preset step, and then from a fully protected state.

// File: rtl/fspg_pkg.sv
package fspg_pkg;

  // Default geometry: 2**6-1 big sectors, 2**3 boot sectors, big groups of 2**2.
  localparam int unsigned FSPG_BIG_BITS   = 6;
  localparam int unsigned FSPG_SMALL_BITS = 3;
  localparam int unsigned FSPG_GRP_SHIFT  = 2;
  localparam int unsigned FSPG_OFFS_W     = 12;

  typedef enum logic {
    BOOT_BOTTOM = 1'b0,
    BOOT_TOP    = 1'b1
  } boot_e;

  function automatic int unsigned fspg_n_big(int unsigned big_bits);
    return (1 << big_bits) - 1;
  endfunction

  function automatic int unsigned fspg_n_big_grp(int unsigned big_bits, int unsigned grp_shift);
    return (fspg_n_big(big_bits) + (1 << grp_shift) - 1) >> grp_shift;
  endfunction

  function automatic int unsigned fspg_n_sec(int unsigned big_bits, int unsigned small_bits);
    return fspg_n_big(big_bits) + (1 << small_bits);
  endfunction

  function automatic int unsigned fspg_n_grp(int unsigned big_bits, int unsigned small_bits,
                                             int unsigned grp_shift);
    return fspg_n_big_grp(big_bits, grp_shift) + (1 << small_bits);
  endfunction

endpackage

// File: rtl/fspg_sector_map.sv
module fspg_sector_map #(
  parameter fspg_pkg::boot_e BOOT       = fspg_pkg::BOOT_TOP,
  parameter int unsigned     BIG_BITS   = fspg_pkg::FSPG_BIG_BITS,
  parameter int unsigned     SMALL_BITS = fspg_pkg::FSPG_SMALL_BITS,
  parameter int unsigned     GRP_SHIFT  = fspg_pkg::FSPG_GRP_SHIFT,
  parameter int unsigned     OFFS_W     = fspg_pkg::FSPG_OFFS_W,
  localparam int unsigned    SEC_W      = BIG_BITS + SMALL_BITS,
  localparam int unsigned    ADDR_W     = SEC_W + OFFS_W + 1,
  localparam int unsigned    SEC_IDX_W  = $clog2(fspg_pkg::fspg_n_sec(BIG_BITS, SMALL_BITS)),
  localparam int unsigned    GRP_W      = $clog2(fspg_pkg::fspg_n_grp(BIG_BITS, SMALL_BITS, GRP_SHIFT))
) (
  input  logic [ADDR_W-1:0]    lin_addr,
  input  logic                 byte_mode,
  output logic [SEC_IDX_W-1:0] sec_idx,
  output logic [GRP_W-1:0]     grp_idx,
  output logic                 is_small,
  output logic                 is_outer
);

  localparam int unsigned N_SMALL   = 1 << SMALL_BITS;
  localparam int unsigned N_BIG     = fspg_pkg::fspg_n_big(BIG_BITS);
  localparam int unsigned N_BIG_GRP = fspg_pkg::fspg_n_big_grp(BIG_BITS, GRP_SHIFT);

  logic [SEC_W-1:0]      field;
  logic [BIG_BITS-1:0]   hi;
  logic [SMALL_BITS-1:0] lo;

  // Byte addresses carry one extra low bit, so the field sits one place higher.
  assign field = byte_mode ? lin_addr[ADDR_W-1 -: SEC_W] : lin_addr[ADDR_W-2 -: SEC_W];
  assign hi    = field[SEC_W-1:SMALL_BITS];
  assign lo    = field[SMALL_BITS-1:0];

  if (BOOT == fspg_pkg::BOOT_TOP) begin : g_top
    // Boot sectors occupy the last big slot (hi all ones).
    always_comb begin
      is_small = &hi;
      is_outer = is_small && (lo >= SMALL_BITS'(N_SMALL - 2));
      if (is_small) begin
        sec_idx = SEC_IDX_W'(N_BIG) + SEC_IDX_W'(lo);
        grp_idx = GRP_W'(N_BIG_GRP) + GRP_W'(lo);
      end else begin
        sec_idx = SEC_IDX_W'(hi);
        grp_idx = GRP_W'(hi >> GRP_SHIFT);
      end
    end
  end else begin : g_bottom
    // Boot sectors occupy the first big slot (hi all zeros).
    always_comb begin
      is_small = ~|hi;
      is_outer = is_small && (lo < SMALL_BITS'(2));
      if (is_small) begin
        sec_idx = SEC_IDX_W'(lo);
        grp_idx = GRP_W'(lo);
      end else begin
        sec_idx = SEC_IDX_W'(hi) + SEC_IDX_W'(N_SMALL - 1);
        grp_idx = GRP_W'(N_SMALL) + GRP_W'(hi >> GRP_SHIFT);
      end
    end
  end

endmodule

// File: rtl/fspg_prot_store.sv
module fspg_prot_store #(
  parameter int unsigned   N_GRP     = 24,
  parameter int unsigned   GRP_W     = $clog2(N_GRP),
  parameter logic [N_GRP-1:0] PROT_INIT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_req,
  input  logic [GRP_W-1:0] grp_sel,
  input  logic             chip_req,
  output logic [N_GRP-1:0] bits,
  output logic             all_set
);

  assign all_set = &bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits <= PROT_INIT;
    end else if (chip_req) begin
      // Clear only from the fully protected state; otherwise protect everything first.
      bits <= all_set ? '0 : '1;
    end else if (set_req) begin
      for (int g = 0; g < int'(N_GRP); g++) begin
        if (grp_sel == GRP_W'(g)) bits[g] <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/fspg_policy.sv
module fspg_policy (
  input  logic stored_bit,
  input  logic is_outer,
  input  logic wp_n,
  input  logic acc_active,
  input  logic temp_unprot,
  output logic locked
);

  logic wp_guard;
  logic stored_live;

  assign wp_guard    = is_outer && !wp_n;
  assign stored_live = stored_bit && !temp_unprot;
  assign locked      = !acc_active && (wp_guard || stored_live);

endmodule

// File: rtl/fspg_gate.sv
module fspg_gate #(
  parameter fspg_pkg::boot_e BOOT       = fspg_pkg::BOOT_TOP,
  parameter int unsigned     BIG_BITS   = fspg_pkg::FSPG_BIG_BITS,
  parameter int unsigned     SMALL_BITS = fspg_pkg::FSPG_SMALL_BITS,
  parameter int unsigned     GRP_SHIFT  = fspg_pkg::FSPG_GRP_SHIFT,
  parameter int unsigned     OFFS_W     = fspg_pkg::FSPG_OFFS_W,
  localparam int unsigned    N_GRP      = fspg_pkg::fspg_n_grp(BIG_BITS, SMALL_BITS, GRP_SHIFT),
  parameter logic [N_GRP-1:0] PROT_INIT = '0,
  localparam int unsigned    SEC_W      = BIG_BITS + SMALL_BITS,
  localparam int unsigned    ADDR_W     = SEC_W + OFFS_W + 1,
  localparam int unsigned    SEC_IDX_W  = $clog2(fspg_pkg::fspg_n_sec(BIG_BITS, SMALL_BITS)),
  localparam int unsigned    GRP_W      = $clog2(N_GRP)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    lin_addr,
  input  logic                 byte_mode,
  input  logic                 op_req,
  input  logic                 prot_grp_req,
  input  logic                 chip_unprot_req,
  input  logic                 wp_n,
  input  logic                 acc_active,
  input  logic                 temp_unprot,
  output logic [SEC_IDX_W-1:0] sector_idx,
  output logic [GRP_W-1:0]     group_idx,
  output logic                 sect_locked,
  output logic                 eff_locked,
  output logic                 op_ack,
  output logic                 op_allow
);

  // Internal events brought out for the checker.
  logic             is_small;
  logic             is_outer;
  logic [N_GRP-1:0] grp_bits;
  logic             all_set;
  logic             grp_valid;

  fspg_sector_map #(
    .BOOT(BOOT), .BIG_BITS(BIG_BITS), .SMALL_BITS(SMALL_BITS),
    .GRP_SHIFT(GRP_SHIFT), .OFFS_W(OFFS_W)
  ) i_map (
    .lin_addr (lin_addr),
    .byte_mode(byte_mode),
    .sec_idx  (sector_idx),
    .grp_idx  (group_idx),
    .is_small (is_small),
    .is_outer (is_outer)
  );

  fspg_prot_store #(
    .N_GRP(N_GRP), .GRP_W(GRP_W), .PROT_INIT(PROT_INIT)
  ) i_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_req (prot_grp_req),
    .grp_sel (group_idx),
    .chip_req(chip_unprot_req),
    .bits    (grp_bits),
    .all_set (all_set)
  );

  assign grp_valid = 32'(group_idx) < N_GRP;

  always_comb begin
    sect_locked = 1'b0;
    if (grp_valid) sect_locked = grp_bits[group_idx];
  end

  fspg_policy i_policy (
    .stored_bit (sect_locked),
    .is_outer   (is_outer),
    .wp_n       (wp_n),
    .acc_active (acc_active),
    .temp_unprot(temp_unprot),
    .locked     (eff_locked)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_ack   <= 1'b0;
      op_allow <= 1'b0;
    end else begin
      op_ack   <= op_req;
      op_allow <= op_req && !eff_locked;
    end
  end

endmodule

// File: rtl/fspg_gate_chk.sv
module fspg_gate_chk #(
  parameter int unsigned N_GRP = 24,
  parameter int unsigned GRP_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_req,
  input logic             prot_grp_req,
  input logic             chip_unprot_req,
  input logic             acc_active,
  input logic             wp_n,
  input logic             is_outer,
  input logic [GRP_W-1:0] group_idx,
  input logic [N_GRP-1:0] grp_bits,
  input logic             all_set,
  input logic             op_ack,
  input logic             op_allow
);

  AST_ACK_ONE_LATER: assert property (@(posedge clk) disable iff (!rst_n)
    op_req |=> op_ack); // R4

  AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    op_ack |-> $past(op_req)); // R4

  AST_ALLOW_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    op_allow |-> op_ack); // R4

  AST_ACC_OPENS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    op_req && acc_active |=> op_allow); // R8

  AST_WP_GUARDS_OUTER: assert property (@(posedge clk) disable iff (!rst_n)
    op_req && is_outer && !wp_n && !acc_active |=> !op_allow); // R6

  AST_GRP_BIT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    prot_grp_req && !chip_unprot_req && (32'(group_idx) < N_GRP)
    |=> ((grp_bits >> $past(group_idx)) & N_GRP'(1)) != '0); // R5

  AST_CHIP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    chip_unprot_req && all_set |=> grp_bits == '0); // R10

  AST_CHIP_PRESETS: assert property (@(posedge clk) disable iff (!rst_n)
    chip_unprot_req && !all_set |=> &grp_bits); // R10

  AST_BITS_PERSIST: assert property (@(posedge clk) disable iff (!rst_n)
    !prot_grp_req && !chip_unprot_req |=> $stable(grp_bits)); // R9

endmodule

bind fspg_gate fspg_gate_chk #(.N_GRP(N_GRP), .GRP_W(GRP_W)) i_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .op_req         (op_req),
  .prot_grp_req   (prot_grp_req),
  .chip_unprot_req(chip_unprot_req),
  .acc_active     (acc_active),
  .wp_n           (wp_n),
  .is_outer       (is_outer),
  .group_idx      (group_idx),
  .grp_bits       (grp_bits),
  .all_set        (all_set),
  .op_ack         (op_ack),
  .op_allow       (op_allow)
);

// File: tb/test_fspg_gate.sv
module test_fspg_gate;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [21:0] lin_addr = '0;
  logic        byte_mode = 1'b0;
  logic        op_req = 1'b0, prot_grp_req = 1'b0, chip_unprot_req = 1'b0;
  logic        wp_n = 1'b1, acc_active = 1'b0, temp_unprot = 1'b0;

  logic [6:0]  sec_t, sec_b;
  logic [4:0]  grp_t, grp_b;
  logic        lk_t, lk_b, ek_t, ek_b, ack_t, ack_b, alw_t, alw_b;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fspg_gate #(.BOOT(fspg_pkg::BOOT_TOP)) i_fspg_gate (
    .clk(clk), .rst_n(rst_n), .lin_addr(lin_addr), .byte_mode(byte_mode),
    .op_req(op_req), .prot_grp_req(prot_grp_req), .chip_unprot_req(chip_unprot_req),
    .wp_n(wp_n), .acc_active(acc_active), .temp_unprot(temp_unprot),
    .sector_idx(sec_t), .group_idx(grp_t), .sect_locked(lk_t), .eff_locked(ek_t),
    .op_ack(ack_t), .op_allow(alw_t));

  fspg_gate #(.BOOT(fspg_pkg::BOOT_BOTTOM)) i_fspg_gate_bot (
    .clk(clk), .rst_n(rst_n), .lin_addr(lin_addr), .byte_mode(byte_mode),
    .op_req(op_req), .prot_grp_req(prot_grp_req), .chip_unprot_req(chip_unprot_req),
    .wp_n(wp_n), .acc_active(acc_active), .temp_unprot(temp_unprot),
    .sector_idx(sec_b), .group_idx(grp_b), .sect_locked(lk_b), .eff_locked(ek_b),
    .op_ack(ack_b), .op_allow(alw_b));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [21:0] mk(input int f, input bit bm);
    if (bm) return (22'(f) << 13) | 22'h00A5;
    return (22'(f) << 12) | 22'h003C;
  endfunction

  // Expected decode, written from the requirement arithmetic.
  function automatic int top_sec(input int f);
    return (f >= 504) ? 63 + (f - 504) : f / 8;
  endfunction
  function automatic int top_grp(input int f);
    return (f >= 504) ? 16 + (f - 504) : f / 32;
  endfunction
  function automatic int bot_sec(input int f);
    return (f < 8) ? f : f / 8 + 7;
  endfunction
  function automatic int bot_grp(input int f);
    return (f < 8) ? f : 8 + f / 32;
  endfunction
  // Field value that addresses top-boot sector s.
  function automatic int top_field(input int s);
    return (s < 63) ? s * 8 : 504 + (s - 63);
  endfunction

  task automatic look(input int f);
    @(negedge clk);
    lin_addr = mk(f, 1'b0);
    byte_mode = 1'b0;
    #1;
  endtask

  task automatic do_op(input int f);
    @(negedge clk);
    lin_addr = mk(f, 1'b0);
    byte_mode = 1'b0;
    op_req = 1'b1;
    @(negedge clk);
    op_req = 1'b0;
  endtask

  task automatic prot_at(input int f);
    @(negedge clk);
    lin_addr = mk(f, 1'b0);
    byte_mode = 1'b0;
    prot_grp_req = 1'b1;
    @(negedge clk);
    prot_grp_req = 1'b0;
  endtask

  task automatic chip_req();
    @(negedge clk);
    chip_unprot_req = 1'b1;
    @(negedge clk);
    chip_unprot_req = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R11: protect bits reset to PROT_INIT (all zero) and no acknowledge is pending
    chk("R11 ack after reset", int'(ack_t), 0);
    for (int s = 0; s < 71; s++) begin
      lin_addr = mk(top_field(s), 1'b0);
      #1;
      chk("R11 reset bit", int'(lk_t), 0);
    end

    // R1 R2 R3: exhaustive decode in both address modes and both layouts
    for (int f = 0; f < 512; f++) begin
      for (int bm = 0; bm < 2; bm++) begin
        lin_addr = mk(f, bit'(bm));
        byte_mode = bit'(bm);
        #1;
        chk(bm ? "R3 R1 top sector" : "R1 top sector", int'(sec_t), top_sec(f));
        chk(bm ? "R3 R1 top group" : "R1 top group", int'(grp_t), top_grp(f));
        chk(bm ? "R3 R2 bot sector" : "R2 bot sector", int'(sec_b), bot_sec(f));
        chk(bm ? "R3 R2 bot group" : "R2 bot group", int'(grp_b), bot_grp(f));
      end
    end
    // R3: bit 21 is unused in word mode
    lin_addr = mk(9 * 8, 1'b0) | 22'h200000;
    byte_mode = 1'b0;
    #1;
    chk("R3 word mode top bit", int'(sec_t), 9);

    // R4: unprotected sector is allowed, acknowledged one cycle later
    do_op(top_field(0));
    chk("R4 ack", int'(ack_t), 1);
    chk("R4 allow", int'(alw_t), 1);
    @(negedge clk);
    chk("R4 ack single cycle", int'(ack_t), 0);

    // R5: protect group 2 (sectors 8..11)
    prot_at(top_field(9));
    for (int s = 7; s <= 12; s++) begin
      look(top_field(s));
      chk("R5 group 2 readout", int'(lk_t), (s >= 8 && s <= 11) ? 1 : 0);
    end
    do_op(top_field(10));
    chk("R4 protected ignored", int'(alw_t), 0);
    chk("R4 ack on ignore", int'(ack_t), 1);
    do_op(top_field(12));
    chk("R4 neighbour allowed", int'(alw_t), 1);

    // R5: three-sector group 15 (60..62), must not reach boot sector 63
    prot_at(top_field(61));
    for (int s = 59; s <= 63; s++) begin
      look(top_field(s));
      chk("R5 group 15 readout", int'(lk_t), (s >= 60 && s <= 62) ? 1 : 0);
    end

    // R6: write protect guards 69 and 70 regardless of stored bits
    wp_n = 1'b0;
    do_op(top_field(69));
    chk("R6 wp top 69", int'(alw_t), 0);
    do_op(top_field(70));
    chk("R6 wp top 70", int'(alw_t), 0);
    do_op(top_field(68));
    chk("R6 wp top 68 free", int'(alw_t), 1);

    // R7: with wp high the outer sectors follow the stored bits
    wp_n = 1'b1;
    do_op(top_field(69));
    chk("R7 wp high 69 allowed", int'(alw_t), 1);
    prot_at(top_field(70));
    do_op(top_field(70));
    chk("R7 wp high 70 stored", int'(alw_t), 0);

    // R8: acceleration opens everything, even under wp
    acc_active = 1'b1;
    do_op(top_field(9));
    chk("R8 acc stored", int'(alw_t), 1);
    wp_n = 1'b0;
    do_op(top_field(69));
    chk("R8 acc over wp", int'(alw_t), 1);
    acc_active = 1'b0;
    wp_n = 1'b1;

    // R9: temporary unprotect, wp guard still applies, bits kept
    temp_unprot = 1'b1;
    do_op(top_field(9));
    chk("R9 temp stored", int'(alw_t), 1);
    do_op(top_field(70));
    chk("R9 temp outer wp high", int'(alw_t), 1);
    wp_n = 1'b0;
    do_op(top_field(69));
    chk("R9 temp keeps wp", int'(alw_t), 0);
    wp_n = 1'b1;
    look(top_field(9));
    chk("R9 bit kept", int'(lk_t), 1);
    temp_unprot = 1'b0;
    do_op(top_field(9));
    chk("R9 protection back", int'(alw_t), 0);

    // R10: partial state -> chip request protects all
    chip_req();
    for (int s = 0; s < 71; s++) begin
      lin_addr = mk(top_field(s), 1'b0);
      #1;
      chk("R10 preset all", int'(lk_t), 1);
    end
    // R10: fully protected -> chip request clears all
    chip_req();
    for (int s = 0; s < 71; s++) begin
      lin_addr = mk(top_field(s), 1'b0);
      #1;
      chk("R10 clear all", int'(lk_t), 0);
    end
    // R10: chip request wins over group protect in the same cycle
    prot_at(top_field(0));
    @(negedge clk);
    lin_addr = mk(top_field(5), 1'b0);
    chip_unprot_req = 1'b1;
    prot_grp_req = 1'b1;
    @(negedge clk);
    chip_unprot_req = 1'b0;
    prot_grp_req = 1'b0;
    #1;
    chk("R10 priority preset", int'(lk_t), 1);
    chip_req();
    look(top_field(5));
    chk("R10 priority cleared", int'(lk_t), 0);

    // R6: bottom layout outer sectors 0 and 1
    wp_n = 1'b0;
    do_op(0);
    chk("R6 wp bottom 0", int'(alw_b), 0);
    do_op(1);
    chk("R6 wp bottom 1", int'(alw_b), 0);
    do_op(2);
    chk("R6 wp bottom 2 free", int'(alw_b), 1);
    do_op(511);
    chk("R6 wp bottom top end free", int'(alw_b), 1);
    wp_n = 1'b1;

    done = 1'b1;
    finish_run();
  end

endmodule